// File: doc/BRIEF.md
# Channel Event Scaler Bank

The block keeps one free-running event counter for each output channel of a trigger stage. On every clock where a channel's fire strobe is high, that channel's counter advances by one. Software reads the counters and two control registers through a simple 16-bit register port. Each counter is read as two 16-bit halves. Reading the low half captures the upper half of the same count value, so the two halves always belong together.

A counter can be cleared in two ways. Software can set a hold-to-zero bit for that counter. An external timing-reset pulse can also clear it, but only on channels whose arm bit software has set. A clear always overrides an increment in the same clock.

Top module: `scaler_bank`

## Requirements
- R1: After reset, every counter reads zero, both control registers read 0x0000, and `reg_rdata` is 0x0000.
- R2: A counter increments by exactly one on each clock edge where its `chan_fire` bit is 1 and no clear applies to it. It holds its value on every other edge.
- R3: A counter at its all-ones value (CNT_W bits) that fires moves to zero.
- R4: While bit n of the force register (address 3, bit n) is 1, counter n stays at zero on every edge after the write, even when its channel fires.
- R5: A `timing_rst` pulse clears counter n only if bit n of the arm register (address 2, bit n) is 1. Counters whose arm bit is 0 are unaffected.
- R6: When a clear and an increment of the same counter fall in the same clock, the counter becomes zero.
- R7: Both control registers (address 2 = arm, address 3 = force) store and return all 16 written bits. Bits 15:NUM_CH have no effect on any counter.
- R8: Counter n's low half is read at address 40+2n and its high half at 41+2n. A read issued with `reg_rd` at one edge appears on `reg_rdata` after that edge. `reg_rdata` is 0x0000 on any clock without a read.
- R9: A read of counter n's low half stores counter n's current upper half. A later read of the high half returns that stored value, even if the counter has since changed.
- R10: Writes to counter addresses or unmapped addresses change nothing. Reads of unmapped addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the clock after `reg_rd` |
| chan_fire | input | NUM_CH | Per-channel increment strobes |
| timing_rst | input | 1 | External timing reset pulse, gated per channel by the arm bits |

## Verification
The bench builds the block with CNT_W set to 17 and all other parameters at their defaults. With that width, a counter's high half becomes non-zero after 65,536 fires and the counter wraps after 131,072. This puts the wrap and the half-word snapshot across a carry into the high half within a short run. The four channels and the real address map are kept, so arm and force masks that mix active and idle channels are exercised as built.

// File: rtl/scaler_pkg.sv
package scaler_pkg;

    localparam int REG_W = 16;

    typedef struct packed {
        logic [REG_W-1:0] arm;
        logic [REG_W-1:0] hold;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_ARM   = 2'd1,
        SEL_HOLD  = 2'd2
    } ctrl_sel_e;

endpackage

// File: rtl/scaler_ctrl_regs.sv
module scaler_ctrl_regs
    import scaler_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int ADDR_ARM  = 2,
    parameter int ADDR_HOLD = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output ctrl_t             ctrl
);

    typedef struct packed {
        ctrl_t regs;
    } regs_state_t;

    regs_state_t s_d, s_q;
    ctrl_sel_e   sel;

    always_comb begin
        sel = SEL_NONE;
        if (wr_en && addr == ADDR_W'(ADDR_ARM))  sel = SEL_ARM;
        if (wr_en && addr == ADDR_W'(ADDR_HOLD)) sel = SEL_HOLD;

        s_d = s_q;
        case (sel)
            SEL_ARM:  s_d.regs.arm  = wdata;
            SEL_HOLD: s_d.regs.hold = wdata;
            default:  ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl = s_q.regs;

    p_arm_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_ARM)) |=> ctrl.arm == $past(wdata));

    p_hold_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(ADDR_HOLD)) |=> ctrl.hold == $past(wdata));

    p_no_write_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

endmodule

// File: rtl/scaler_counter.sv
module scaler_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic             hold_zero,
    input  logic             armed,
    input  logic             timing_rst,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       clr;

    always_comb begin
        clr = hold_zero | (timing_rst & armed);
        s_d = s_q;
        if (clr)       s_d.cnt = '0;
        else if (fire) s_d.cnt = s_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count = s_q.cnt;

    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hold_zero && !(timing_rst && armed)) |=> count == $past(count) + CNT_W'(1));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !hold_zero && !(timing_rst && armed)) |=> $stable(count));

    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !hold_zero && !(timing_rst && armed) && count == {CNT_W{1'b1}}) |=> count == '0);

    p_force_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hold_zero |=> count == '0);

    p_armed_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (timing_rst && armed) |=> count == '0);

    p_clear_beats_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (hold_zero || (timing_rst && armed))) |=> count == '0);

endmodule

// File: rtl/scaler_readout.sv
module scaler_readout
    import scaler_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 6,
    parameter int ADDR_ARM  = 2,
    parameter int ADDR_HOLD = 3,
    parameter int ADDR_BASE = 40
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  ctrl_t                        ctrl,
    input  logic [NUM_CH-1:0][CNT_W-1:0] counts,
    output logic [REG_W-1:0]             rdata
);

    localparam int WIDE_W = 2 * REG_W;

    typedef struct packed {
        logic [NUM_CH-1:0][REG_W-1:0] snap;
        logic [REG_W-1:0]             rdata;
    } rd_state_t;

    rd_state_t                     s_d, s_q;
    logic [NUM_CH-1:0][WIDE_W-1:0] wide_cnt;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            wide_cnt[c]            = '0;
            wide_cnt[c][CNT_W-1:0] = counts[c];
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        if (rd_en) begin
            if (addr == ADDR_W'(ADDR_ARM))  s_d.rdata = ctrl.arm;
            if (addr == ADDR_W'(ADDR_HOLD)) s_d.rdata = ctrl.hold;
            for (int c = 0; c < NUM_CH; c++) begin
                if (addr == ADDR_W'(ADDR_BASE + 2 * c)) begin
                    s_d.rdata   = wide_cnt[c][REG_W-1:0];
                    s_d.snap[c] = wide_cnt[c][WIDE_W-1:REG_W];
                end
                if (addr == ADDR_W'(ADDR_BASE + 2 * c + 1)) begin
                    s_d.rdata = s_q.snap[c];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata = s_q.rdata;

    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> rdata == '0);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
        p_low_half_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(ADDR_BASE + 2 * g)) |=> rdata == $past(counts[g][REG_W-1:0]));

        p_high_from_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == ADDR_W'(ADDR_BASE + 2 * g + 1)) |=> rdata == $past(s_q.snap[g]));
    end

endmodule

// File: rtl/scaler_bank.sv
module scaler_bank
    import scaler_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int CNT_W     = 32,
    parameter int ADDR_W    = 6,
    parameter int ADDR_ARM  = 2,
    parameter int ADDR_HOLD = 3,
    parameter int ADDR_BASE = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [NUM_CH-1:0] chan_fire,
    input  logic              timing_rst
);

    ctrl_t                        ctrl;
    logic [NUM_CH-1:0][CNT_W-1:0] counts;

    scaler_ctrl_regs #(
        .ADDR_W    (ADDR_W),
        .ADDR_ARM  (ADDR_ARM),
        .ADDR_HOLD (ADDR_HOLD)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        scaler_counter #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk        (clk),
            .rst_n      (rst_n),
            .fire       (chan_fire[n]),
            .hold_zero  (ctrl.hold[n]),
            .armed      (ctrl.arm[n]),
            .timing_rst (timing_rst),
            .count      (counts[n])
        );
    end

    scaler_readout #(
        .NUM_CH    (NUM_CH),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .ADDR_ARM  (ADDR_ARM),
        .ADDR_HOLD (ADDR_HOLD),
        .ADDR_BASE (ADDR_BASE)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_en  (reg_rd),
        .addr   (reg_addr),
        .ctrl   (ctrl),
        .counts (counts),
        .rdata  (reg_rdata)
    );

endmodule

// File: tb/sim_scaler_bank.sv
module sim_scaler_bank;

    localparam int NUM_CH = 4;
    localparam int CNT_W  = 17;
    localparam int ADDR_W = 6;
    localparam int MASK   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [15:0]       reg_wdata = '0;
    logic [15:0]       reg_rdata;
    logic [NUM_CH-1:0] chan_fire = '0;
    logic              timing_rst = 1'b0;

    int checks = 0;
    int fails  = 0;
    int exp_cnt [NUM_CH];

    scaler_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_fire(chan_fire), .timing_rst(timing_rst)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        reg_wr = 1'b1; reg_addr = ADDR_W'(a); reg_wdata = 16'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic bus_read(input int a, output int d);
        reg_rd = 1'b1; reg_addr = ADDR_W'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = int'(reg_rdata);
    endtask

    task automatic read_count(input int ch, output int v);
        int lo, hi;
        bus_read(40 + 2 * ch, lo);
        bus_read(41 + 2 * ch, hi);
        v = (hi << 16) | lo;
    endtask

    task automatic fire_for(input logic [NUM_CH-1:0] m, input int n);
        chan_fire = m;
        repeat (n) @(negedge clk);
        chan_fire = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (m[c]) exp_cnt[c] = (exp_cnt[c] + n) & MASK;
    endtask

    task automatic check_all(input string req);
        int v;
        for (int c = 0; c < NUM_CH; c++) begin
            read_count(c, v);
            check(req, v, exp_cnt[c]);
        end
    endtask

    task automatic t_reset;
        int v;
        check("R1 rdata", int'(reg_rdata), 0);
        bus_read(2, v); check("R1 arm", v, 0);
        bus_read(3, v); check("R1 force", v, 0);
        check_all("R1 counters");
    endtask

    task automatic t_count;
        fire_for(4'b0001, 5);
        fire_for(4'b0010, 9);
        fire_for(4'b0101, 3);
        repeat (6) @(negedge clk);
        check_all("R2 R8 counts");
    endtask

    task automatic t_ctrl_rw;
        int v;
        bus_write(2, 16'hA5C0); bus_read(2, v); check("R7 arm rb", v, 16'hA5C0);
        bus_write(3, 16'hFFF0); bus_read(3, v); check("R7 force rb", v, 16'hFFF0);
        timing_rst = 1'b1; @(negedge clk); timing_rst = 1'b0;
        check_all("R7 upper bits no effect");
        bus_write(2, 0); bus_write(3, 0);
    endtask

    task automatic t_force;
        int v;
        bus_write(3, 16'h0002);
        exp_cnt[1] = 0;
        fire_for(4'b1111, 4);
        exp_cnt[1] = 0;
        check_all("R4 R6 force hold");
        bus_write(3, 0);
        fire_for(4'b0010, 2);
        read_count(1, v); check("R4 release", v, 2);
    endtask

    task automatic t_timing;
        bus_write(2, 16'h0005);
        chan_fire = 4'b1111; timing_rst = 1'b1;
        @(negedge clk);
        chan_fire = '0; timing_rst = 1'b0;
        exp_cnt[0] = 0; exp_cnt[2] = 0;
        exp_cnt[1] = exp_cnt[1] + 1; exp_cnt[3] = exp_cnt[3] + 1;
        check_all("R5 R6 armed clear");
        fire_for(4'b0101, 7);
        bus_write(2, 0);
        timing_rst = 1'b1; @(negedge clk); timing_rst = 1'b0;
        check_all("R5 unarmed keep");
    endtask

    task automatic t_ignored;
        int v;
        bus_write(40, 16'h1234); bus_write(41, 16'h0001);
        bus_write(47, 16'hFFFF); bus_write(10, 16'h00FF);
        check_all("R10 writes ignored");
        bus_read(10, v); check("R10 unmapped rd", v, 0);
        bus_read(63, v); check("R10 unmapped rd hi", v, 0);
        bus_read(2, v);  check("R10 arm untouched", v, 0);
    endtask

    task automatic t_wrap_snap;
        int v;
        bus_write(3, 16'h0008); bus_write(3, 0);
        exp_cnt[3] = 0;
        fire_for(4'b1000, 65540);
        bus_read(46, v); check("R8 low half", v, 4);
        bus_read(47, v); check("R8 high half", v, 1);
        fire_for(4'b1000, 65531);
        bus_read(46, v); check("R9 low at max", v, 16'hFFFF);
        fire_for(4'b1000, 1);
        bus_read(47, v); check("R9 snapshot kept", v, 1);
        bus_read(46, v); check("R3 wrap low", v, 0);
        bus_read(47, v); check("R3 wrap high", v, 0);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        for (int c = 0; c < NUM_CH; c++) exp_cnt[c] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_ctrl_rw();
        t_force();
        t_timing();
        t_ignored();
        t_wrap_snap();
        finish_run();
    end

endmodule